// File: doc/BRIEF.md
# Vector Issue Rate Limiter

This block gates the issue ports of a SIMD compute unit's vector ALU. For every port it keeps a down-counter that holds the port's ready signal low for as long as the last accepted instruction occupies the port. The hold length depends on the instruction's class. A small table gives each class a native throughput, and the occupancy is that throughput expressed as a power-of-two multiple of a four-cycle base.

A static configuration input, which stands in for a blown fuse, can lengthen the hold of double-precision instructions. Their native half rate then drops to one-eighth rate. The arithmetic itself is not touched. The configuration can only make the hold longer. When the hardware is built with a native double-precision rate of one-sixteenth, the fuse therefore has no effect.

The issue arbiter sees one ready bit per port. The arbiter may present a request on any cycle, and a request counts only when the port is ready.

Top module: `issue_rate_limiter`

## Requirements
- R1: During reset and on the first cycle after reset release, every `port_ready_o` bit is 1.
- R2: Instruction classes 0, 1 and 4 to 7 are full rate. An accepted one keeps its port busy for 4 cycles, so the next issue on that port is possible 4 clock edges later.
- R3: A request is accepted at a clock edge where `issue_valid_i` and `port_ready_o` are both 1 for that port. After acceptance, `port_ready_o` is 0 for exactly occupancy−1 cycles and then 1 again. With requests held asserted, consecutive accepts are spaced exactly by the occupancy.
- R4: Class 3 (transcendental) runs at quarter rate, with an occupancy of 16 cycles.
- R5: Class 2 (double precision) runs at its native half rate with an occupancy of 8 cycles when the fuse input was 0 during reset.
- R6: Class 2 is forced to one-eighth rate, with an occupancy of 32 cycles, when the fuse input was 1 during reset.
- R7: A request while the port is busy is ignored. It neither restarts nor lengthens the busy window.
- R8: The fuse input is captured only while `rst_n` is 0. Changes to it after reset release have no effect on any occupancy.
- R9: Ports are independent. Activity on one port never changes another port's ready signal.
- R10: The effective rate is the slower of the native and the fuse-forced rate. In a build whose native double-precision rate is one-sixteenth, class 2 occupies 64 cycles whatever the fuse value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the fuse is sampled while it is low |
| fuse_dp_slow_i | input | 1 | Static configuration bit: 1 forces double precision to one-eighth rate |
| issue_valid_i | input | NUM_PORTS | Per-port issue request from the arbiter |
| issue_class_i | input | NUM_PORTS*CLASS_W | Per-port instruction class, port p in bits [p*CLASS_W +: CLASS_W] |
| port_ready_o | output | NUM_PORTS | Per-port ready; 0 means the port is stalled |

## Verification
There is a single register between an accepted request and the ready output. An accept at clock edge t therefore pulls `port_ready_o` low in the cycle that follows t, and the output returns high just before edge t+occupancy. The bench drives requests at the falling edge. It advances a reference count per port at the rising edge and compares `port_ready_o` with that count at the next falling edge. Every cycle of every busy window is therefore checked, not only its ends. A second instance, built with one-sixteenth native double-precision rate, runs on the same stimulus so that the rate merge is checked when the fuse is redundant.

// File: rtl/rl_pkg.sv
package rl_pkg;

    // Rate classes; occupancy is the base cycle count shifted left by the code.
    typedef enum logic [2:0] {
        RATE_FULL      = 3'd0,
        RATE_HALF      = 3'd1,
        RATE_QUARTER   = 3'd2,
        RATE_EIGHTH    = 3'd3,
        RATE_SIXTEENTH = 3'd4
    } rate_e;

    localparam int unsigned CLS_DP    = 2;
    localparam int unsigned CLS_TRANS = 3;

    function automatic rate_e rate_slower(rate_e a, rate_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rl_fuse_latch.sv
module rl_fuse_latch #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fuse_i,
    output logic [W-1:0] fuse_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } fuse_st_t;

    fuse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.bits = fuse_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fuse_o = st_q.bits;

    // R8: once out of reset the captured configuration never moves
    p_fuse_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(fuse_o));

endmodule

// File: rtl/rl_rate_table.sv
module rl_rate_table
    import rl_pkg::*;
#(
    parameter int unsigned CLASS_W     = 3,
    parameter int unsigned BASE_CYCLES = 4,
    parameter int unsigned CNT_W       = 6,
    parameter rate_e       DP_NATIVE   = RATE_HALF,
    parameter rate_e       TRANS_RATE  = RATE_QUARTER
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CLASS_W-1:0] cls_i,
    input  logic               fuse_dp_slow_i,
    output logic [CNT_W-1:0]   occ_m1_o
);
    localparam int unsigned NUM_CLASSES = 1 << CLASS_W;

    rate_e native_tab [NUM_CLASSES];
    rate_e native_rate;
    rate_e forced_rate;
    rate_e eff_rate;

    for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_tab
        if (g == CLS_DP) begin : g_dp
            assign native_tab[g] = DP_NATIVE;
        end else if (g == CLS_TRANS) begin : g_tr
            assign native_tab[g] = TRANS_RATE;
        end else begin : g_full
            assign native_tab[g] = RATE_FULL;
        end
    end

    always_comb begin
        native_rate = native_tab[cls_i];
        forced_rate = RATE_FULL;
        if (fuse_dp_slow_i && (int'(cls_i) == CLS_DP)) begin
            forced_rate = RATE_EIGHTH;
        end
        eff_rate = rate_slower(native_rate, forced_rate);
        occ_m1_o = CNT_W'((BASE_CYCLES << eff_rate) - 1);
    end

    // R10: the configuration never makes a class faster than its table entry
    p_never_faster_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eff_rate >= native_rate);

    // R6: a set fuse leaves double precision at one-eighth rate or slower
    p_dp_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_dp_slow_i && int'(cls_i) == CLS_DP) |-> (occ_m1_o >= CNT_W'(BASE_CYCLES * 8 - 1)));

endmodule

// File: rtl/rl_port_timer.sv
module rl_port_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid_i,
    input  logic [CNT_W-1:0] occ_m1_i,
    output logic             port_ready_o
);
    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.remain != '0) begin
            st_d.remain = st_q.remain - 1'b1;
        end else if (issue_valid_i) begin
            st_d.remain = occ_m1_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign port_ready_o = (st_q.remain == '0);

    // R3: an accepted issue stalls the port on the following cycle
    p_stall_after_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_i && port_ready_o) |=> !port_ready_o);

    // R7: a busy port keeps counting down whatever the request line does
    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_ready_o && issue_valid_i) |=> (st_q.remain == $past(st_q.remain) - 1'b1));

    // R3: an idle port with no request stays idle
    p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ready_o && !issue_valid_i) |=> port_ready_o);

endmodule

// File: rtl/issue_rate_limiter.sv
module issue_rate_limiter
    import rl_pkg::*;
#(
    parameter int unsigned NUM_PORTS      = 2,
    parameter int unsigned CLASS_W        = 3,
    parameter int unsigned BASE_CYCLES    = 4,
    parameter rate_e       DP_NATIVE_RATE = RATE_HALF,
    parameter rate_e       TRANS_RATE     = RATE_QUARTER
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           fuse_dp_slow_i,
    input  logic [NUM_PORTS-1:0]           issue_valid_i,
    input  logic [NUM_PORTS*CLASS_W-1:0]   issue_class_i,
    output logic [NUM_PORTS-1:0]           port_ready_o
);
    localparam int unsigned MAX_OCC = BASE_CYCLES << RATE_SIXTEENTH;
    localparam int unsigned CNT_W   = $clog2(MAX_OCC);

    logic fuse_q;

    rl_fuse_latch #(.W(1)) u_fuse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fuse_i (fuse_dp_slow_i),
        .fuse_o (fuse_q)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [CNT_W-1:0] occ_m1;

        rl_rate_table #(
            .CLASS_W     (CLASS_W),
            .BASE_CYCLES (BASE_CYCLES),
            .CNT_W       (CNT_W),
            .DP_NATIVE   (DP_NATIVE_RATE),
            .TRANS_RATE  (TRANS_RATE)
        ) u_tab (
            .clk            (clk),
            .rst_n          (rst_n),
            .cls_i          (issue_class_i[p*CLASS_W +: CLASS_W]),
            .fuse_dp_slow_i (fuse_q),
            .occ_m1_o       (occ_m1)
        );

        rl_port_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk           (clk),
            .rst_n         (rst_n),
            .issue_valid_i (issue_valid_i[p]),
            .occ_m1_i      (occ_m1),
            .port_ready_o  (port_ready_o[p])
        );

        // R2: a full-rate class never needs less than the base occupancy
        p_min_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
            occ_m1 >= CNT_W'(BASE_CYCLES - 1));
    end

endmodule

// File: tb/tb_issue_rate_limiter.sv
module tb_issue_rate_limiter;
    import rl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 2;
    localparam int CW         = 3;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             rst_n;
    logic             fuse;
    logic [NP-1:0]    vld;
    logic [NP*CW-1:0] cls;
    logic [NP-1:0]    rdy_a, rdy_b;

    int  n_chk = 0;
    int  n_bad = 0;
    int  rem     [2][NP];
    int  lastcls [2][NP];
    bit  ignored [2][NP];
    bit  fuse_lat;
    bit  iso;
    bit  done = 1'b0;

    issue_rate_limiter #(.NUM_PORTS(NP), .CLASS_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .fuse_dp_slow_i(fuse),
        .issue_valid_i(vld), .issue_class_i(cls), .port_ready_o(rdy_a));

    issue_rate_limiter #(.NUM_PORTS(NP), .CLASS_W(CW),
                         .DP_NATIVE_RATE(RATE_SIXTEENTH)) dut16 (
        .clk(clk), .rst_n(rst_n), .fuse_dp_slow_i(fuse),
        .issue_valid_i(vld), .issue_class_i(cls), .port_ready_o(rdy_b));

    // Occupancy from the requirements: R2, R4, R5, R6, R10
    function automatic int exp_occ(int c, bit f, bit n16);
        if (c == 2) return n16 ? 64 : (f ? 32 : 8);
        if (c == 3) return 16;
        return 4;
    endfunction

    function automatic string tag_for(int d, int p);
        if (iso && p == 1)                  return "R9";
        if (ignored[d][p])                  return "R7";
        if (lastcls[d][p] == 2 && d == 1)   return "R10";
        if (lastcls[d][p] == 2 && fuse != fuse_lat) return "R8";
        if (lastcls[d][p] == 2)             return fuse_lat ? "R6" : "R5";
        if (lastcls[d][p] == 3)             return "R4";
        return "R2";
    endfunction

    task automatic check(string tag, int d, int p, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (R3 timing) inst %0d port %0d: ready actual %0b expected %0b at %0t",
                     tag, d, p, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < NP; p++) begin
                check(tag_for(d, p), d, p, d == 0 ? rdy_a[p] : rdy_b[p], rem[d][p] == 0);
            end
        end
    endtask

    // Reference update at the rising edge, from the inputs the bench drove
    task automatic model_edge();
        if (!rst_n) fuse_lat = fuse;
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < NP; p++) begin
                if (!rst_n) begin
                    rem[d][p] = 0;
                end else if (rem[d][p] > 0) begin
                    rem[d][p]--;
                    if (vld[p]) ignored[d][p] = 1'b1;
                end else if (vld[p]) begin
                    lastcls[d][p] = int'(cls[p*CW +: CW]);
                    rem[d][p]     = exp_occ(lastcls[d][p], fuse_lat, d == 1) - 1;
                    ignored[d][p] = 1'b0;
                end
            end
        end
    endtask

    task automatic do_reset(bit f);
        @(negedge clk);
        rst_n = 1'b0; fuse = f; vld = '0;
        repeat (3) begin
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1: all ports ready right after release
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < NP; p++)
                check("R1", d, p, d == 0 ? rdy_a[p] : rdy_b[p], 1'b1);
        @(posedge clk);
        model_edge();
    endtask

    task automatic run(int cycles, int pct, bit toggle_fuse, bit p1_idle);
        iso = p1_idle;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_all();
            for (int p = 0; p < NP; p++) begin
                vld[p] = (($urandom % 100) < pct) && !(p1_idle && p == 1);
                cls[p*CW +: CW] = CW'($urandom % 8);
            end
            // R8: wiggle the fuse after reset; the reference ignores it
            if (toggle_fuse && ($urandom % 40) == 0) fuse = ~fuse;
            @(posedge clk);
            model_edge();
        end
        iso = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1D5EED);
        rst_n = 1'b0; fuse = 1'b0; vld = '0; cls = '0; iso = 1'b0; fuse_lat = 1'b0;
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < NP; p++) begin
                rem[d][p] = 0; lastcls[d][p] = 0; ignored[d][p] = 1'b0;
            end
        for (int f = 0; f < 2; f++) begin
            do_reset(f[0]);
            run(400, 100, 1'b0, 1'b0);   // back-to-back requests, R3 spacing
            run(3000, 60, 1'b1, 1'b0);   // mixed density, fuse wiggling
            run(400, 100, 1'b0, 1'b1);   // port 1 idle while port 0 busy
            run(200, 20, 1'b1, 1'b0);    // sparse requests
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule